// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a memory-mapped timer built around one down-counter. Software programs it through a small word-indexed register bus with a combinational read path. It writes a start or reload count and a control word. The counter then steps down once per prescaler tick. When the count reaches zero, the block latches an interrupt flag and can drive an interrupt line.

The behaviour at zero depends on the mode. In periodic mode the counter restarts from the reload value. In free-running mode it wraps to the all-ones value of the selected width. In one-shot mode it parks at zero until software loads a new count. Two registers set the reload value. One of them also restarts the count at once. The other takes effect only at the next zero. The count can be 16 or 32 bits wide, and the tick rate divides the clock by 1, 16 or 256.

Top module: `dcnt_timer`

## Requirements
- R1: After reset, the control word reads 0, the value register reads 0x0000FFFF (the all-ones count seen in the default 16-bit mode), the reload value reads 0, the raw status reads 0 and `irq` is low.
- R2: Register word index 0 holds the immediate load. A write to it sets the reload value and replaces the count in the next cycle. Index 0 and index 6 both read back the reload value. Index 1 reads the current count, and writes to index 1 are ignored. Index 3 reads as zero.
- R3: A write to index 6 changes only the reload value. The running count is untouched, and the new value is used at the next zero in periodic mode.
- R4: Control bit 7 enables counting. While bit 7 is clear, the count holds its value. While it is set, the count drops by one on every prescaler tick.
- R5: The raw status (index 4, bit 0) sets on the tick that takes the count from 1 to 0. In periodic mode (control bit 6 set), the next tick loads the reload value, so a reload value L gives one zero event every L+1 ticks.
- R6: In free-running mode (control bits 6 and 0 clear), the tick that finds the count at zero loads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R7: With control bit 0 set (one-shot), the counter stops at zero and holds there. A later write to index 0 restarts it.
- R8: Control bit 1 set selects a 32-bit count; clear selects 16 bits. In 16-bit mode, only bits 15:0 take part in reads, in decrementing and in zero detection.
- R9: Control bits 3:2 set the tick rate: 00 is every cycle, 01 is every 16 cycles, 10 is every 256 cycles, and 11 is every cycle. With 01 or 10, the first tick comes 16 or 256 cycles after counting is enabled or the count is loaded.
- R10: A write of any data to index 3 clears the raw status. If a zero event happens in the same cycle, the status stays set.
- R11: The masked status (index 5, bit 0) and `irq` both equal the raw status ANDed with control bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request (raw status AND enable) |

## Verification
The bench builds the block with its defaults: a 32-bit data path, a 16-bit narrow mode, and divider exponents of 4 and 8. These values keep a full 16-bit wrap and a divide-by-256 first tick within a few hundred cycles, so both are checked at their exact cycle. They also make the 16-bit masking visible against a 32-bit load carrying upper bits. The cycle of each zero event, reload, wrap and prescaler tick is predicted by counting bus slots from the control write.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

   typedef enum logic [2:0] {
      IDX_LOAD  = 3'd0,
      IDX_VALUE = 3'd1,
      IDX_CTRL  = 3'd2,
      IDX_CLR   = 3'd3,
      IDX_RAW   = 3'd4,
      IDX_MASK  = 3'd5,
      IDX_BG    = 3'd6
   } reg_idx_e;

   // bit 7 down to bit 0
   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       irq_en;
      logic       rsvd;
      logic [1:0] div;
      logic       wide;
      logic       oneshot;
   } tmr_ctrl_t;

   localparam logic [1:0] DIV_ONE  = 2'b00;
   localparam logic [1:0] DIV_MID  = 2'b01;
   localparam logic [1:0] DIV_HIGH = 2'b10;

   localparam logic [7:0] CTRL_WRITE_MASK = 8'hEF;

endpackage

// File: rtl/dcnt_prescale.sv
module dcnt_prescale #(
   parameter int unsigned DIV_A_LOG2 = 4,
   parameter int unsigned DIV_B_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] div_sel,
   output logic       tick
);
   import dcnt_pkg::*;

   localparam int unsigned PRE_W = DIV_B_LOG2;

   initial begin
      assert (DIV_A_LOG2 >= 1 && DIV_A_LOG2 < DIV_B_LOG2)
         else $fatal(1, "dcnt_prescale: divider exponents out of order");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (!run || restart) pre_q <= '0;
      else                     pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      case (div_sel)
         DIV_MID:  tick = run & (&pre_q[DIV_A_LOG2-1:0]);
         DIV_HIGH: tick = run & (&pre_q);
         default:  tick = run;
      endcase
   end

   AST_MID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && $past(div_sel) == DIV_MID && div_sel == DIV_MID) |-> !tick); // R9

endmodule

// File: rtl/dcnt_core.sv
module dcnt_core #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned HALF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             periodic,
   input  logic             oneshot,
   input  logic             wide,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count_o,
   output logic             zero_evt
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   initial begin
      assert (HALF_W >= 1 && HALF_W < CNT_W)
         else $fatal(1, "dcnt_core: narrow width must be below full width");
   end

   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur;
   logic             halted_q;
   logic             step;

   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      if (i < HALF_W) begin : g_lo
         assign mask[i] = 1'b1;
      end else begin : g_hi
         assign mask[i] = wide;
      end
   end

   assign cur      = cnt_q & mask;
   assign step     = tick & run & ~halted_q & ~load_wr;
   assign zero_evt = step && (cur == ONE);
   assign count_o  = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '1;
         halted_q <= 1'b0;
      end else if (load_wr) begin
         cnt_q    <= load_val;
         halted_q <= 1'b0;
      end else if (step) begin
         if (cur == '0) begin
            cnt_q <= (periodic || oneshot) ? reload_val : mask;
         end else begin
            cnt_q <= (cur - 1'b1) & mask;
            if (oneshot && cur == ONE) halted_q <= 1'b1;
         end
      end
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> (cnt_q == $past(load_val))); // R2
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load_wr) |=> $stable(cnt_q)); // R4
   AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !periodic && !oneshot && cur == '0) |=> (cnt_q == $past(mask))); // R6
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !load_wr) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned HALF_W     = 16,
   parameter int unsigned DIV_A_LOG2 = 4,
   parameter int unsigned DIV_B_LOG2 = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import dcnt_pkg::*;

   localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

   initial begin
      assert (DATA_W > CTRL_W && DATA_W > HALF_W)
         else $fatal(1, "dcnt_timer: data width too small");
   end

   reg_idx_e          idx;
   tmr_ctrl_t         ctrl_q;
   logic [DATA_W-1:0] reload_q;
   logic              raw_q;
   logic              load_wr, bg_wr, ctrl_wr, clr_wr;
   logic              tick, zero_evt;
   logic [DATA_W-1:0] count;

   assign idx     = reg_idx_e'(bus_addr);
   assign load_wr = bus_we && idx == IDX_LOAD;
   assign bg_wr   = bus_we && idx == IDX_BG;
   assign ctrl_wr = bus_we && idx == IDX_CTRL;
   assign clr_wr  = bus_we && idx == IDX_CLR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         raw_q    <= 1'b0;
      end else begin
         if (ctrl_wr)          ctrl_q   <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0] & CTRL_WRITE_MASK);
         if (load_wr || bg_wr) reload_q <= bus_wdata;
         if (zero_evt)         raw_q    <= 1'b1;
         else if (clr_wr)      raw_q    <= 1'b0;
      end
   end

   dcnt_prescale #(
      .DIV_A_LOG2 (DIV_A_LOG2),
      .DIV_B_LOG2 (DIV_B_LOG2)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run),
      .restart (load_wr),
      .div_sel (ctrl_q.div),
      .tick    (tick)
   );

   dcnt_core #(
      .CNT_W  (DATA_W),
      .HALF_W (HALF_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (ctrl_q.run),
      .periodic   (ctrl_q.periodic),
      .oneshot    (ctrl_q.oneshot),
      .wide       (ctrl_q.wide),
      .load_wr    (load_wr),
      .load_val   (bus_wdata),
      .reload_val (reload_q),
      .count_o    (count),
      .zero_evt   (zero_evt)
   );

   assign irq = raw_q & ctrl_q.irq_en;

   always_comb begin
      bus_rdata = '0;
      case (idx)
         IDX_LOAD, IDX_BG: bus_rdata = reload_q;
         IDX_VALUE:        bus_rdata = count;
         IDX_CTRL:         bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
         IDX_RAW:          bus_rdata = {{(DATA_W-1){1'b0}}, raw_q};
         IDX_MASK:         bus_rdata = {{(DATA_W-1){1'b0}}, irq};
         default:          bus_rdata = '0;
      endcase
   end

   AST_RAW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> raw_q); // R5
   AST_RAW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q) |-> $past(zero_evt)); // R5
   AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !zero_evt) |=> !raw_q); // R10
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.irq_en |-> !irq); // R11

endmodule

// File: tb/dcnt_timer_test.sv
module dcnt_timer_test;

   localparam logic [2:0] A_LOAD = 3'd0, A_VAL = 3'd1, A_CTRL = 3'd2, A_CLR = 3'd3,
                          A_RAW = 3'd4, A_MSK = 3'd5, A_BG = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [2:0]  addr;
      logic [31:0] exp;
      string       tag;
   } exp_item_t;

   exp_item_t sb_q[$];

   always #5 clk = ~clk;

   dcnt_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // monitor: one expected item per falling edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_irq ? {31'b0, irq} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      #1;
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
      exp_item_t it;
      #1;
      bus_addr = a;
      it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      exp_item_t it;
      #1;
      it.is_irq = 1'b1; it.addr = bus_addr; it.exp = {31'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(A_CTRL, 32'h0, "R1 ctrl");
      chk(A_VAL, 32'h0000FFFF, "R1 value");
      chk(A_RAW, 32'h0, "R1 raw");
      chk_irq(1'b0, "R1 irq");
      chk(A_LOAD, 32'h0, "R1 reload");

      // R2 register map
      wr(A_LOAD, 32'd5);
      chk(A_VAL, 32'd5, "R2 load sets count");
      chk(A_BG, 32'd5, "R2 bg reads reload");
      chk(A_CLR, 32'd0, "R2 clr reads zero");
      wr(A_VAL, 32'h1234);
      chk(A_VAL, 32'd5, "R2 value write ignored");

      // R4 R5 R11 periodic, irq enabled, 32-bit
      wr(A_CTRL, 32'hE2);
      chk(A_VAL, 32'd4, "R4 step1");
      chk(A_VAL, 32'd3, "R4 step2");
      chk(A_VAL, 32'd2, "R4 step3");
      chk(A_VAL, 32'd1, "R4 step4");
      chk(A_RAW, 32'd1, "R5 raw at zero");
      chk_irq(1'b1, "R11 irq high");
      chk(A_VAL, 32'd4, "R5 periodic reload");
      chk(A_MSK, 32'd1, "R11 masked set");
      wr(A_CLR, 32'h0);
      chk(A_RAW, 32'd0, "R10 cleared");
      chk(A_RAW, 32'd1, "R5 next period");
      wr(A_CTRL, 32'hC2);
      chk(A_MSK, 32'd0, "R11 masked off");
      chk_irq(1'b0, "R11 irq off");
      chk(A_RAW, 32'd1, "R11 raw kept");
      wr(A_CTRL, 32'h0);
      idle(2);
      chk(A_VAL, 32'd1, "R4 frozen");
      wr(A_CLR, 32'h0);

      // R3 background reload
      wr(A_LOAD, 32'd3);
      wr(A_BG, 32'd7);
      chk(A_VAL, 32'd3, "R3 count kept");
      chk(A_LOAD, 32'd7, "R3 reload updated");
      wr(A_CTRL, 32'hC2);
      idle(3);
      chk(A_VAL, 32'd7, "R3 used at zero");

      // R6 free-running wraps
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'd2);
      wr(A_CTRL, 32'h80);
      idle(2);
      chk(A_VAL, 32'h0000FFFF, "R6 wrap 16");
      chk(A_VAL, 32'h0000FFFE, "R6 after wrap 16");
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'd1);
      wr(A_CTRL, 32'h82);
      idle(1);
      chk(A_VAL, 32'hFFFFFFFF, "R6 wrap 32");

      // R8 width
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'h1234_0003);
      chk(A_VAL, 32'h0000_0003, "R8 narrow read");
      wr(A_CTRL, 32'h02);
      chk(A_VAL, 32'h1234_0003, "R8 wide read");
      wr(A_CLR, 32'h0);
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'h0001_0001);
      wr(A_CTRL, 32'hC0);
      chk(A_RAW, 32'd1, "R8 narrow zero detect");

      // R7 one-shot
      wr(A_CTRL, 32'h0);
      wr(A_CLR, 32'h0);
      wr(A_LOAD, 32'd2);
      wr(A_CTRL, 32'hC3);
      idle(4);
      chk(A_VAL, 32'd0, "R7 parked");
      chk(A_RAW, 32'd1, "R7 raw");
      wr(A_LOAD, 32'd2);
      chk(A_VAL, 32'd1, "R7 restart");

      // R10 set wins over clear
      wr(A_CTRL, 32'h0);
      wr(A_CLR, 32'h0);
      chk(A_RAW, 32'd0, "R10 clear");
      wr(A_LOAD, 32'd2);
      wr(A_CTRL, 32'hC2);
      chk(A_VAL, 32'd1, "R10 pre");
      wr(A_CLR, 32'h0);
      chk(A_RAW, 32'd1, "R10 set wins");

      // R9 prescaler
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'd100);
      wr(A_CTRL, 32'hC6);
      idle(14);
      chk(A_VAL, 32'd100, "R9 div16 before");
      chk(A_VAL, 32'd99, "R9 div16 tick");
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'd100);
      wr(A_CTRL, 32'hCA);
      idle(254);
      chk(A_VAL, 32'd100, "R9 div256 before");
      chk(A_VAL, 32'd99, "R9 div256 tick");
      wr(A_CTRL, 32'h0);
      wr(A_LOAD, 32'd100);
      wr(A_CTRL, 32'hCE);
      chk(A_VAL, 32'd99, "R9 code3 every cycle");

      done = 1'b1;
      finish_run();
   end

endmodule